// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block turns a stream of 4-bit transmit nibbles into the three-level line code of a 100 Mb/s twisted-pair link. It runs on the 125 MHz bit clock. A divide-by-five counter produces a nibble strobe, and the MAC side drives the nibble and the frame-valid flag for that strobe. At each strobe the framer picks one 5-bit code group: a data code, a delimiter or idle. The serializer then sends that group one bit per clock, least significant bit first. Each bit is whitened by an 11-bit scrambler, NRZI coded and finally mapped to a three-level MLT-3 symbol. The symbol is given as a 2-bit two's-complement value.

Each port seeds its scrambler from its 5-bit station address, so ports sharing a cable bundle do not emit the same pattern. Two static controls let a test or a special mode skip stages. One skips the nibble-to-group mapping, so that raw 5-bit groups go straight to the serializer. The other skips the scrambler.

Top module: `tx100_symbol_encoder`

## Requirements
- R1: `nib_stb` is high for exactly one clock in every five. The inputs `tx_en`, `txd` and `enc_bypass` are taken at the rising edge that ends a strobe cycle. The first strobe comes in the fifth clock after reset is released.
- R2: When `tx_en` is first seen high with the encoder active, the group for that strobe is J (11000). The group for the next strobe is K (10001), whatever the inputs are. These two groups take the place of the first two nibbles of the frame.
- R3: At each later strobe with `tx_en` high, the nibble `txd[3:0]` maps to its data group. The groups for 0..F are: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. `txd[4]` is ignored.
- R4: The first strobe in a frame's data phase with `tx_en` low sends T (01101). The next strobe sends R (00111). After that, idle groups (11111) are sent until `tx_en` is seen high again.
- R5: A group chosen at a strobe is sent over the next five clocks, bit 0 first. Before the first strobe after reset, five idle 1 bits are sent.
- R6: The scrambler is an 11-bit register s. Each clock, the key k = s[10] XOR s[8] is XORed onto the serial bit and s becomes {s[9:0], k}. The register advances every clock, even when the scrambler is bypassed, and it never holds all zeros.
- R7: While reset is held, the scrambler loads {1, addr[4:0], ~addr[4:0]}. This makes the output sequences of different addresses differ.
- R8: With `scr_bypass` high, the unscrambled serial bit passes straight to the NRZI stage.
- R9: With `enc_bypass` high, `txd[4:0]` is sent as the group at every strobe, whatever `tx_en` is. No delimiters are added, and the framer stays idle.
- R10: `nrzi` toggles at each clock whose line bit is 1 and holds at each clock whose line bit is 0.
- R11: `mlt` steps through 0, +1, 0, -1 (codes 00, 01, 00, 11) at each line bit of 1 and holds at each line bit of 0. It never takes the code 10, and it never moves between +1 and -1 in one step.
- R12: During reset (synchronous, active low), `mlt` is 0, `nrzi` is 0 and the framer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phy_addr | input | 5 | Station address used for the scrambler seed |
| enc_bypass | input | 1 | Send raw 5-bit groups from `txd` |
| scr_bypass | input | 1 | Pass serial bits unscrambled |
| tx_en | input | 1 | Frame valid, taken at the strobe |
| txd | input | 5 | Nibble in [3:0], full raw group when bypassed |
| nib_stb | output | 1 | Nibble strobe, one clock in five |
| nrzi | output | 1 | NRZI coded line bit |
| mlt | output | 2 | MLT-3 level, two's complement (-1, 0, +1) |

## Verification
Two functions can land on the same strobe: closing one frame with R and opening the next with J. The bench makes them collide by raising `tx_en` again at the strobe that sends R, and also by sending a frame that is only two nibbles long, so that T follows K at once. The scoreboard holds the expected group order, and a bench-side model of the scrambler and line coder predicts each output symbol. A correct design must send R in full and then J at the next strobe, with no missing or extra idle group.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int GRP_W  = 5;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 5;
  localparam int SCR_W  = 2 * ADDR_W + 1;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_K    = 2'd1,
    FR_DATA = 2'd2,
    FR_R    = 2'd3
  } fr_state_e;

  localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
  localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
  localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
  localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
  localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;

  // Nibble to data code group.
  function automatic logic [GRP_W-1:0] enc_nibble(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: return 5'b11110;
      4'h1: return 5'b01001;
      4'h2: return 5'b10100;
      4'h3: return 5'b10101;
      4'h4: return 5'b01010;
      4'h5: return 5'b01011;
      4'h6: return 5'b01110;
      4'h7: return 5'b01111;
      4'h8: return 5'b10010;
      4'h9: return 5'b10011;
      4'hA: return 5'b10110;
      4'hB: return 5'b10111;
      4'hC: return 5'b11010;
      4'hD: return 5'b11011;
      4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  // Address to scrambler seed; top bit forced high so the seed is never zero.
  function automatic logic [SCR_W-1:0] seed_of(input logic [ADDR_W-1:0] a);
    return {1'b1, a, ~a};
  endfunction

  // MLT-3 phase (0..3) to two's-complement level.
  function automatic logic [1:0] mlt_level(input logic [1:0] ph);
    case (ph)
      2'd1:    return 2'b01;
      2'd3:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/txs_framer.sv
module txs_framer
  import txs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             tx_en_i,
  input  logic [GRP_W-1:0] txd_i,
  input  logic             enc_bypass_i,
  output logic [GRP_W-1:0] group_o,
  output fr_state_e        state_o
);

  fr_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    group_o = CG_IDLE;
    if (enc_bypass_i) begin
      group_o = txd_i;
      st_d    = FR_IDLE;
    end else begin
      unique case (st_q)
        FR_IDLE: if (tx_en_i) begin
          group_o = CG_J;
          st_d    = FR_K;
        end
        FR_K: begin
          group_o = CG_K;
          st_d    = FR_DATA;
        end
        FR_DATA: if (tx_en_i) begin
          group_o = enc_nibble(txd_i[NIB_W-1:0]);
        end else begin
          group_o = CG_T;
          st_d    = FR_R;
        end
        FR_R: begin
          group_o = CG_R;
          st_d    = FR_IDLE;
        end
        default: st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= FR_IDLE;
    else if (load_i) st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/txs_serializer.sv
module txs_serializer #(
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] group_i,
  output logic          stb_o,
  output logic          bit_o
);

  localparam int CW = $clog2(GW);
  localparam logic [CW-1:0] LAST = CW'(GW - 1);

  logic [CW-1:0] cnt_q;
  logic [GW-1:0] sh_q;

  assign stb_o = (cnt_q == LAST);
  assign bit_o = sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '1;
    end else if (stb_o) begin
      cnt_q <= '0;
      sh_q  <= group_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {1'b1, sh_q[GW-1:1]};
    end
  end

endmodule

// File: rtl/txs_scrambler.sv
module txs_scrambler #(
  parameter int SW    = 11,
  parameter int TAP_A = 10,
  parameter int TAP_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] seed_i,
  input  logic          bypass_i,
  input  logic          bit_i,
  output logic          bit_o,
  output logic [SW-1:0] state_o
);

  logic [SW-1:0] lfsr_q;
  logic          key;

  assign key     = lfsr_q[TAP_A] ^ lfsr_q[TAP_B];
  assign bit_o   = bypass_i ? bit_i : (bit_i ^ key);
  assign state_o = lfsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= seed_i;
    else        lfsr_q <= {lfsr_q[SW-2:0], key};
  end

endmodule

// File: rtl/txs_line_coder.sv
module txs_line_coder
  import txs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_i,
  output logic       nrzi_o,
  output logic [1:0] mlt_o
);

  logic [1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrzi_o  <= 1'b0;
      phase_q <= 2'd0;
    end else if (bit_i) begin
      nrzi_o  <= ~nrzi_o;
      phase_q <= phase_q + 2'd1;
    end
  end

  assign mlt_o = mlt_level(phase_q);

endmodule

// File: rtl/tx100_symbol_encoder.sv
module tx100_symbol_encoder
  import txs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              enc_bypass,
  input  logic              scr_bypass,
  input  logic              tx_en,
  input  logic [GRP_W-1:0]  txd,
  output logic              nib_stb,
  output logic              nrzi,
  output logic [1:0]        mlt
);

  logic [GRP_W-1:0] group;
  fr_state_e        fr_st;
  logic             ser_bit;
  logic             scr_bit;
  logic [SCR_W-1:0] lfsr_q;

  txs_framer u_framer (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (nib_stb),
    .tx_en_i      (tx_en),
    .txd_i        (txd),
    .enc_bypass_i (enc_bypass),
    .group_o      (group),
    .state_o      (fr_st)
  );

  txs_serializer #(.GW(GRP_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .group_i (group),
    .stb_o   (nib_stb),
    .bit_o   (ser_bit)
  );

  txs_scrambler #(.SW(SCR_W), .TAP_A(SCR_W - 1), .TAP_B(SCR_W - 3)) u_scr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_i   (seed_of(phy_addr)),
    .bypass_i (scr_bypass),
    .bit_i    (ser_bit),
    .bit_o    (scr_bit),
    .state_o  (lfsr_q)
  );

  txs_line_coder u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (scr_bit),
    .nrzi_o (nrzi),
    .mlt_o  (mlt)
  );

endmodule

// File: rtl/txs_checker.sv
module txs_checker
  import txs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stb,
  input logic             enc_bypass,
  input logic [GRP_W-1:0] group,
  input fr_state_e        st,
  input logic             scr_bit,
  input logic [SCR_W-1:0] lfsr,
  input logic             nrzi,
  input logic [1:0]       mlt
);

  // R1
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R2
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !enc_bypass && group == CG_J) |=> (st == FR_K));

  // R4
  t_then_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !enc_bypass && group == CG_T) |=> (st == FR_R));

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R10
  nrzi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scr_bit |=> (nrzi != $past(nrzi)));

  // R10
  nrzi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_bit |=> $stable(nrzi));

  // R11
  mlt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mlt != 2'b10);

  // R11
  mlt_no_jump_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt == 2'b01) |=> (mlt != 2'b11));

  // R11
  mlt_no_jump_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mlt == 2'b11) |=> (mlt != 2'b01));

  // R11
  mlt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_bit |=> $stable(mlt));

endmodule

bind tx100_symbol_encoder txs_checker u_txs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb        (nib_stb),
  .enc_bypass (enc_bypass),
  .group      (group),
  .st         (fr_st),
  .scr_bit    (scr_bit),
  .lfsr       (lfsr_q),
  .nrzi       (nrzi),
  .mlt        (mlt)
);

// File: tb/test_tx100_symbol_encoder.sv
module test_tx100_symbol_encoder;

  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] phy_addr = 5'h03;
  logic       enc_bypass = 1'b0;
  logic       scr_bypass = 1'b0;
  logic       tx_en = 1'b0;
  logic [4:0] txd = 5'h00;
  logic       nib_stb;
  logic       nrzi;
  logic [1:0] mlt;

  int checks = 0;
  int errors = 0;
  string cur_req = "R5";

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx100_symbol_encoder i_tx100_symbol_encoder (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .enc_bypass(enc_bypass),
    .scr_bypass(scr_bypass), .tx_en(tx_en), .txd(txd),
    .nib_stb(nib_stb), .nrzi(nrzi), .mlt(mlt)
  );

  // Data group table (R3), index = nibble value.
  localparam logic [4:0] DATA_TBL [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101 };

  // Scoreboard queue of expected serial bits, plus the line model.
  bit          exp_q[$];
  bit          pend;
  bit          mon_on = 1'b0;
  logic [10:0] m_lfsr;
  bit          m_nrzi;
  int          m_pos;
  int          m_fr;        // 0 idle, 1 K next, 2 data, 3 R next
  int          cyc;
  int          last_stb;
  logic [31:0] sig;

  task automatic fail(input string req, input string what, input int got, input int exp);
    errors++;
    $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
  endtask

  task automatic push_group(input logic [4:0] g);
    for (int i = 0; i < 5; i++) exp_q.push_back(g[i]);
  endtask

  // Driver: waits for a strobe cycle, sets the inputs, predicts the group.
  task automatic drive(input bit en, input logic [4:0] d);
    logic [4:0] g;
    do @(negedge clk); while (!nib_stb);
    tx_en = en;
    txd   = d;
    g     = 5'b11111;
    if (enc_bypass) begin
      g = d; m_fr = 0;                                // R9
    end else if (m_fr == 0) begin
      if (en) begin g = 5'b11000; m_fr = 1; end       // R2 J
    end else if (m_fr == 1) begin
      g = 5'b10001; m_fr = 2;                         // R2 K
    end else if (m_fr == 2) begin
      if (en) g = DATA_TBL[d[3:0]];                   // R3
      else begin g = 5'b01101; m_fr = 3; end          // R4 T
    end else begin
      g = 5'b00111; m_fr = 0;                         // R4 R
    end
    push_group(g);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 5'h00);
  endtask

  // Applies one serial bit to the model (R6 R8 R10 R11).
  task automatic apply_bit(input bit b);
    bit k, s;
    k = m_lfsr[10] ^ m_lfsr[8];
    s = scr_bypass ? b : (b ^ k);
    m_lfsr = {m_lfsr[9:0], k};
    if (s) begin
      m_nrzi = ~m_nrzi;
      m_pos  = (m_pos + 1) % 4;
    end
  endtask

  function automatic int exp_level(input int pos);
    return (pos == 1) ? 1 : (pos == 3) ? -1 : 0;
  endfunction

  task automatic do_reset(input logic [4:0] addr);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n  = 1'b0;
    tx_en  = 1'b0;
    phy_addr = addr;
    repeat (3) @(negedge clk);
    checks++;
    if (mlt !== 2'b00) fail("R12", "mlt in reset", int'(mlt), 0);
    checks++;
    if (nrzi !== 1'b0) fail("R12", "nrzi in reset", int'(nrzi), 0);
    m_lfsr = {1'b1, addr, ~addr};                     // R7
    m_nrzi = 1'b0;
    m_pos  = 0;
    m_fr   = 0;
    exp_q.delete();
    push_group(5'b11111);                             // R5 idle before first strobe
    pend     = exp_q.pop_front();
    cyc      = 0;
    last_stb = -1;
    sig      = '0;
    rst_n    = 1'b1;
    mon_on   = 1'b1;
  endtask

  // Monitor: after each rising edge, apply the consumed bit and compare.
  always begin
    @(posedge clk);
    #1;
    if (mon_on) begin
      apply_bit(pend);
      cyc++;
      checks++;
      if (int'($signed(mlt)) != exp_level(m_pos))
        fail({cur_req, " R11"}, "mlt", int'($signed(mlt)), exp_level(m_pos));
      checks++;
      if (nrzi !== m_nrzi) fail({cur_req, " R10"}, "nrzi", int'(nrzi), int'(m_nrzi));
      if (cyc <= 40) sig = {sig[28:0], 3'b000} ^ {30'd0, mlt} ^ {31'd0, nrzi};
      if (nib_stb) begin
        if (last_stb >= 0) begin
          checks++;
          if (cyc - last_stb != 5) fail("R1", "strobe spacing", cyc - last_stb, 5);
        end else begin
          checks++;
          if (cyc != 4) fail("R1", "first strobe cycle", cyc, 4);
        end
        last_stb = cyc;
      end
      if (exp_q.size() == 0) begin
        fail("R5", "scoreboard underflow", 0, 1);
        mon_on = 1'b0;
      end else begin
        pend = exp_q.pop_front();
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired got %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] sig_a;
    logic [31:0] sig_b;

    // Reset state and scrambled idle (R12 R6 R7).
    cur_req = "R6";
    do_reset(5'h03);
    idle_n(4);

    // Full frame across all sixteen nibbles (R2 R3 R4).
    cur_req = "R3";
    drive(1'b1, 5'h05);
    drive(1'b1, 5'h05);
    for (int n = 0; n < 16; n++) drive(1'b1, 5'(n));
    drive(1'b0, 5'h00);
    drive(1'b0, 5'h00);
    idle_n(2);

    // Two-nibble frame: T right after K (R2 R4).
    cur_req = "R4";
    drive(1'b1, 5'h0A);
    drive(1'b0, 5'h0A);
    drive(1'b0, 5'h00);
    // Next frame requested on the strobe that sends R (R4 R2).
    drive(1'b1, 5'h07);
    drive(1'b1, 5'h07);
    drive(1'b1, 5'h07);
    drive(1'b1, 5'h0C);
    drive(1'b0, 5'h00);
    drive(1'b1, 5'h00);
    drive(1'b1, 5'h00);
    drive(1'b1, 5'h00);
    drive(1'b0, 5'h00);
    drive(1'b0, 5'h00);
    idle_n(2);

    // Scrambler bypass with a frame (R8 R5 R10).
    cur_req = "R8";
    scr_bypass = 1'b1;
    drive(1'b1, 5'h00);
    drive(1'b1, 5'h00);
    drive(1'b1, 5'h09);
    drive(1'b1, 5'h0F);
    drive(1'b1, 5'h01);
    drive(1'b0, 5'h00);
    idle_n(3);
    @(negedge clk);
    scr_bypass = 1'b0;
    idle_n(2);

    // Encoder bypass: raw groups, tx_en has no effect (R9).
    cur_req = "R9";
    drive(1'b0, 5'h00);
    @(negedge clk);
    enc_bypass = 1'b1;
    drive(1'b1, 5'h15);
    drive(1'b0, 5'h0A);
    drive(1'b1, 5'h00);
    drive(1'b1, 5'h1F);
    drive(1'b0, 5'h03);
    drive(1'b0, 5'h11);
    @(negedge clk);
    enc_bypass = 1'b0;
    idle_n(2);
    drive(1'b1, 5'h04);                               // fresh frame after bypass
    drive(1'b1, 5'h04);
    drive(1'b1, 5'h02);
    drive(1'b0, 5'h00);
    idle_n(2);

    // Address-dependent seed (R7).
    cur_req = "R7";
    do_reset(5'h00);
    idle_n(9);
    sig_a = sig;
    do_reset(5'h1F);
    idle_n(9);
    sig_b = sig;
    checks++;
    if (sig_a == sig_b) fail("R7", "idle streams equal for two addresses", int'(sig_b), int'(~sig_a));

    @(negedge clk);
    mon_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule